// File: doc/BRIEF.md
# Firmware Image Loader

The block receives a firmware image as a stream of 32-bit words over a valid/ready handshake, with a marker on the final word. It holds the whole image in an internal buffer, then checks it: the three header words (magic, id, size), the descriptor table, and every code block that the table points to. Only when every check has passed does it copy the code blocks into an instruction memory or a data memory, one word per cycle, through a single write port. The port carries a memory select, an address and a data word.

An image whose magic word arrives in reversed byte order is accepted. Every following word is then byte-swapped as it is stored. The load ends with a one-cycle completion pulse that carries a result code. A successful load also raises a one-cycle start pulse for the engine. A failed load writes nothing to either memory.

The controller is one state machine. The states and their transitions are:

- RECEIVE: accepts words and goes to HEADER on the final word.
- HEADER: goes to FAIL on a header error, otherwise to SCAN.
- SCAN: looks for the end marker. It goes to CHECK_DESC when the marker is found, or to FAIL when the payload is exhausted.
- CHECK_DESC: goes to CHECK_BLOCK, to FAIL, or to LOAD_DESC after the last descriptor.
- CHECK_BLOCK: returns to CHECK_DESC, or goes to FAIL.
- LOAD_DESC: goes to LOAD_HEAD, or to DONE_OK after the last descriptor.
- LOAD_HEAD: goes to COPY, or back to LOAD_DESC when the block is empty.
- COPY: returns to LOAD_DESC after the last word of the block.
- DONE_OK and FAIL: both return to RECEIVE.

Top module: `fw_image_loader`

## Requirements
- R1: If the first word equals 0x0DF0EDFE, the byte-reversed form of 0xFEEDF00D, every later word is byte-swapped before use. Such an image loads exactly as its natural-order twin.
- R2: If the first word is neither 0xFEEDF00D nor 0x0DF0EDFE, the load fails with code 1. This check takes priority over every other header check.
- R3: The load fails with code 2 if fewer than 3 words arrive, or if the word count differs from the size word (header word 2) plus 3.
- R4: The load fails with code 3 if id bits 27:24 differ from cfg_engine_id. It fails with code 4 if id bits 31:28 are nonzero while cfg_new_gen is 0.
- R5: The load fails with code 5 if engine_running is high once the header checks have passed.
- R6: The payload begins with two-word descriptors (type, offset); type 0xF ends the table. The load fails with code 6 if no type word equal to 0xF appears at an even payload index below size.
- R7: With N descriptors before the end marker, every descriptor offset must be at least 2N+1 and at most size-2. Otherwise the load fails with code 7.
- R8: A descriptor type other than 0 (instruction memory) or 1 (data memory) fails the load with code 8.
- R9: The block at an offset holds a target address word and a length word. Address plus length must not exceed 0x800 words when cfg_new_gen is 0, or 0x1000 words when it is 1. Otherwise the load fails with code 9.
- R10: If offset + 2 + length exceeds size, the load fails with code 10.
- R11: An image longer than BUF_DEPTH words fails with code 11. This check takes priority over all others.
- R12: Blocks are written in table order, one word per cycle, to consecutive addresses starting at the target address. mem_sel is 0 for instruction memory and 1 for data memory.
- R13: A failed load never drives mem_we. All validation completes before the first write.
- R14: done pulses for one cycle with err_code (0 on success). start pulses together with done only on success. in_ready is high only while words are being received, including just after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_engine_id | input | 4 | Engine number that the image must target |
| cfg_new_gen | input | 1 | 1 selects the newer generation (0x1000-word memories) |
| engine_running | input | 1 | High while the engine executes; a load is then refused |
| in_valid | input | 1 | Image word valid |
| in_ready | output | 1 | Loader accepts a word |
| in_data | input | 32 | Image word |
| in_last | input | 1 | Marks the final word of the image |
| mem_we | output | 1 | Memory write strobe |
| mem_sel | output | 1 | 0 instruction memory, 1 data memory |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 4 | Result code, valid with done |
| start | output | 1 | One-cycle engine start pulse on success |

## Verification
The bench builds one valid image with an instruction block and a data block, then breaks it one field at a time.

- The data block ends on the last word of a 0x800 memory. An off-by-one fit check therefore either rejects a legal image or writes past the end.
- The overflow-by-one variant must fail with no writes, even though the instruction block ahead of it is legal. A loader that validates and writes block by block would have already written that earlier block.
- Offsets exactly one past each bound, a missing end marker, and a table with no entries before the marker probe the table arithmetic.
- Byte-swapped, oversized and doubly-broken images check the swap and the error priority. A wrong priority reports the wrong code.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
    localparam logic [31:0] FW_MAGIC = 32'hFEEDF00D;
    localparam logic [31:0] END_TYPE = 32'h0000000F;

    typedef enum logic [3:0] {
        S_RX, S_HDR, S_SCAN, S_VDESC, S_VBLK, S_WDESC, S_WHDR, S_WDATA, S_OK, S_FAIL
    } fwl_state_t;

    typedef enum logic [3:0] {
        ERR_NONE     = 4'd0,
        ERR_MAGIC    = 4'd1,
        ERR_LENGTH   = 4'd2,
        ERR_ENGINE   = 4'd3,
        ERR_GEN      = 4'd4,
        ERR_BUSY     = 4'd5,
        ERR_NO_END   = 4'd6,
        ERR_OFFSET   = 4'd7,
        ERR_TYPE     = 4'd8,
        ERR_FIT      = 4'd9,
        ERR_SPAN     = 4'd10,
        ERR_OVERFLOW = 4'd11
    } fwl_err_t;

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/fwl_image_buf.sv
module fwl_image_buf #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [31:0]   qa,
    output logic [31:0]   qb
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign qa = mem[ra];
    assign qb = mem[rb];
endmodule

// File: rtl/fwl_hdr_check.sv
module fwl_hdr_check
    import fwl_pkg::*;
(
    input  logic       ovf,
    input  logic       magic_bad,
    input  logic [31:0] nwords,
    input  logic [7:0] id_hi,
    input  logic [31:0] size,
    input  logic [3:0] cfg_engine_id,
    input  logic       cfg_new_gen,
    input  logic       running,
    output fwl_err_t   err
);
    always_comb begin
        if (ovf)                                        err = ERR_OVERFLOW;
        else if (magic_bad)                             err = ERR_MAGIC;
        else if (nwords < 32'd3 ||
                 {1'b0, nwords} != {1'b0, size} + 33'd3) err = ERR_LENGTH;
        else if (id_hi[3:0] != cfg_engine_id)           err = ERR_ENGINE;
        else if (!cfg_new_gen && id_hi[7:4] != 4'd0)    err = ERR_GEN;
        else if (running)                               err = ERR_BUSY;
        else                                            err = ERR_NONE;
    end
endmodule

// File: rtl/fwl_blk_check.sv
module fwl_blk_check
    import fwl_pkg::*;
#(
    parameter int SMALL_DEPTH = 2048,
    parameter int LARGE_DEPTH = 4096
) (
    input  logic [31:0] size,
    input  logic [31:0] nend,
    input  logic [31:0] desc_type,
    input  logic [31:0] desc_off,
    input  logic [31:0] blk_off,
    input  logic [31:0] blk_addr,
    input  logic [31:0] blk_len,
    input  logic        cfg_new_gen,
    output fwl_err_t    desc_err,
    output fwl_err_t    blk_err
);
    localparam logic [32:0] SMALL = 33'(SMALL_DEPTH);
    localparam logic [32:0] LARGE = 33'(LARGE_DEPTH);

    logic [32:0] tbl_end;
    logic [32:0] depth;

    assign tbl_end = {nend, 1'b0} + 33'd1;
    assign depth   = cfg_new_gen ? LARGE : SMALL;

    always_comb begin
        if ({1'b0, desc_off} < tbl_end || {1'b0, desc_off} + 33'd2 > {1'b0, size})
            desc_err = ERR_OFFSET;
        else if (desc_type != 32'd0 && desc_type != 32'd1)
            desc_err = ERR_TYPE;
        else
            desc_err = ERR_NONE;
    end

    always_comb begin
        if ({1'b0, blk_addr} + {1'b0, blk_len} > depth)
            blk_err = ERR_FIT;
        else if ({2'b0, blk_off} + 34'd2 + {2'b0, blk_len} > {2'b0, size})
            blk_err = ERR_SPAN;
        else
            blk_err = ERR_NONE;
    end
endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader
    import fwl_pkg::*;
#(
    parameter int BUF_DEPTH   = 256,
    parameter int MEM_AW      = 12,
    parameter int SMALL_DEPTH = 2048,
    parameter int LARGE_DEPTH = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_engine_id,
    input  logic              cfg_new_gen,
    input  logic              engine_running,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_data,
    input  logic              in_last,
    output logic              mem_we,
    output logic              mem_sel,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              done,
    output logic [3:0]        err_code,
    output logic              start
);
    localparam int AW = $clog2(BUF_DEPTH);

    fwl_state_t state, nxt;
    fwl_err_t   nxt_err, err_q, hdr_err, desc_err, blk_err;

    logic [31:0]       nwords, hdr_size, idx, nend, cur_off, wptr, wleft;
    logic [7:0]        id_hi;
    logic              ovf, magic_bad, swap, cur_sel;
    logic [MEM_AW-1:0] waddr_q;
    logic              acc, buf_we;
    logic [31:0]       in_word, qa, qb;
    logic [AW-1:0]     ra, rb;

    assign in_ready = (state == S_RX);
    assign acc      = in_valid && in_ready;
    assign in_word  = swap ? bswap(in_data) : in_data;
    assign buf_we   = acc && (nwords < 32'(BUF_DEPTH));

    fwl_image_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .we(buf_we), .waddr(AW'(nwords)), .wdata(in_word),
        .ra(ra), .rb(rb), .qa(qa), .qb(qb)
    );

    fwl_hdr_check u_hdr (
        .ovf(ovf), .magic_bad(magic_bad), .nwords(nwords), .id_hi(id_hi),
        .size(hdr_size), .cfg_engine_id(cfg_engine_id), .cfg_new_gen(cfg_new_gen),
        .running(engine_running), .err(hdr_err)
    );

    fwl_blk_check #(.SMALL_DEPTH(SMALL_DEPTH), .LARGE_DEPTH(LARGE_DEPTH)) u_blk (
        .size(hdr_size), .nend(nend), .desc_type(qa), .desc_off(qb),
        .blk_off(cur_off), .blk_addr(qa), .blk_len(qb), .cfg_new_gen(cfg_new_gen),
        .desc_err(desc_err), .blk_err(blk_err)
    );

    // buffer read addresses per state (payload word i sits at buffer index 3+i)
    always_comb begin
        ra = '0;
        rb = '0;
        unique case (state)
            S_SCAN, S_VDESC, S_WDESC: begin
                ra = AW'(32'd3 + (idx << 1));
                rb = AW'(32'd4 + (idx << 1));
            end
            S_VBLK, S_WHDR: begin
                ra = AW'(32'd3 + cur_off);
                rb = AW'(32'd4 + cur_off);
            end
            S_WDATA: ra = AW'(wptr);
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RX;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt     = state;
        nxt_err = ERR_NONE;
        unique case (state)
            S_RX:    if (acc && in_last) nxt = S_HDR;
            S_HDR:   if (hdr_err != ERR_NONE) begin nxt = S_FAIL; nxt_err = hdr_err; end
                     else nxt = S_SCAN;
            S_SCAN:  if ({idx, 1'b0} >= {1'b0, hdr_size}) begin nxt = S_FAIL; nxt_err = ERR_NO_END; end
                     else if (qa == END_TYPE) nxt = S_VDESC;
            S_VDESC: if (idx == nend) nxt = S_WDESC;
                     else if (desc_err != ERR_NONE) begin nxt = S_FAIL; nxt_err = desc_err; end
                     else nxt = S_VBLK;
            S_VBLK:  if (blk_err != ERR_NONE) begin nxt = S_FAIL; nxt_err = blk_err; end
                     else nxt = S_VDESC;
            S_WDESC: nxt = (idx == nend) ? S_OK : S_WHDR;
            S_WHDR:  nxt = (qb == 32'd0) ? S_WDESC : S_WDATA;
            S_WDATA: if (wleft == 32'd1) nxt = S_WDESC;
            S_OK, S_FAIL: nxt = S_RX;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nwords <= '0; hdr_size <= '0; id_hi <= '0; idx <= '0; nend <= '0;
            cur_off <= '0; cur_sel <= 1'b0; wptr <= '0; wleft <= '0; waddr_q <= '0;
            ovf <= 1'b0; magic_bad <= 1'b0; swap <= 1'b0; err_q <= ERR_NONE;
            mem_we <= 1'b0; mem_sel <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
            done <= 1'b0; start <= 1'b0; err_code <= '0;
        end else begin
            mem_we <= 1'b0;
            done   <= 1'b0;
            start  <= 1'b0;
            if (nxt == S_FAIL && state != S_FAIL) err_q <= nxt_err;
            unique case (state)
                S_RX: if (acc) begin
                    nwords <= nwords + 32'd1;
                    if (nwords >= 32'(BUF_DEPTH)) ovf <= 1'b1;
                    if (nwords == 32'd0) begin
                        swap      <= (in_data == bswap(FW_MAGIC));
                        magic_bad <= !(in_data == FW_MAGIC || in_data == bswap(FW_MAGIC));
                    end
                    if (nwords == 32'd1) id_hi    <= in_word[31:24];
                    if (nwords == 32'd2) hdr_size <= in_word;
                end
                S_HDR:   idx <= '0;
                S_SCAN:  if (qa == END_TYPE) begin nend <= idx; idx <= '0; end
                         else idx <= idx + 32'd1;
                S_VDESC: begin
                    cur_off <= qb;
                    if (idx == nend) idx <= '0;
                end
                S_VBLK:  idx <= idx + 32'd1;
                S_WDESC: begin cur_sel <= qa[0]; cur_off <= qb; end
                S_WHDR: begin
                    waddr_q <= qa[MEM_AW-1:0];
                    wleft   <= qb;
                    wptr    <= cur_off + 32'd5;
                    if (qb == 32'd0) idx <= idx + 32'd1;
                end
                S_WDATA: begin
                    mem_we    <= 1'b1;
                    mem_sel   <= cur_sel;
                    mem_addr  <= waddr_q;
                    mem_wdata <= qa;
                    waddr_q   <= waddr_q + 1'b1;
                    wptr      <= wptr + 32'd1;
                    wleft     <= wleft - 32'd1;
                    if (wleft == 32'd1) idx <= idx + 32'd1;
                end
                S_OK, S_FAIL: begin
                    done      <= 1'b1;
                    start     <= (state == S_OK);
                    err_code  <= (state == S_OK) ? 4'd0 : err_q;
                    nwords    <= '0;
                    ovf       <= 1'b0;
                    magic_bad <= 1'b0;
                    swap      <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/fwl_chk.sv
module fwl_chk #(
    parameter int MEM_AW      = 12,
    parameter int SMALL_DEPTH = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_new_gen,
    input logic              in_ready,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              done,
    input logic [3:0]        err_code,
    input logic              start
);
    // R13
    no_write_before_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 4'd0) |-> !$past(mem_we));

    // R14
    start_only_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (done && err_code == 4'd0));

    // R14
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R14
    no_accept_while_writing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !in_ready);

    // R9
    write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !cfg_new_gen) |-> ({1'b0, mem_addr} < (MEM_AW+1)'(SMALL_DEPTH)));
endmodule

bind fw_image_loader fwl_chk #(.MEM_AW(MEM_AW), .SMALL_DEPTH(SMALL_DEPTH)) u_fwl_chk (
    .clk(clk), .rst_n(rst_n), .cfg_new_gen(cfg_new_gen), .in_ready(in_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .done(done), .err_code(err_code), .start(start)
);

// File: tb/tb_fw_image_loader.sv
module tb_fw_image_loader;
    localparam int CLK_PERIOD = 10;
    localparam int BUF_N      = 32;
    localparam int VEC_N      = 15;
    localparam logic [31:0] MAGIC = 32'hFEEDF00D;

    // kinds: 0 ok,1 swap,2 magic,3 size,4 engine,5 gen,6 busy,7 no end,
    //        8 offset low,9 offset high,10 type,11 fit,12 newgen ok,13 span,14 overflow
    localparam logic [3:0] VEC_ERR [VEC_N] = '{4'd0, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5,
        4'd6, 4'd7, 4'd7, 4'd8, 4'd9, 4'd0, 4'd10, 4'd11};

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [3:0]  cfg_engine_id = 4'd1;
    logic        cfg_new_gen = 1'b0, engine_running = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, mem_we, mem_sel, done, start;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  err_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    fw_image_loader #(.BUF_DEPTH(BUF_N)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_engine_id(cfg_engine_id), .cfg_new_gen(cfg_new_gen),
        .engine_running(engine_running), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .mem_we(mem_we), .mem_sel(mem_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .err_code(err_code),
        .start(start)
    );

    int nchk = 0, nfail = 0;
    logic [31:0] img [64];
    logic [44:0] wlog [16];
    int          wn, starts;
    logic        done_seen;
    logic [3:0]  err_seen;

    always @(negedge clk) begin
        if (mem_we) begin
            if (wn < 16) wlog[wn] = {mem_sel, mem_addr, mem_wdata};
            wn = wn + 1;
        end
        if (start) starts = starts + 1;
        if (done) begin done_seen = 1'b1; err_seen = err_code; end
    end

    function automatic logic [31:0] sw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int k);
        case (k)
            0: return "R12";  1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R4";   6: return "R5";   7: return "R6";
            8: return "R7";   9: return "R7";   10: return "R8";  11: return "R9";
            12: return "R9";  13: return "R10"; default: return "R11";
        endcase
    endfunction

    // base image: instr block 3 words at 0x10, data block 2 words at 0x7FE
    function automatic int build(input int k);
        int n = 17;
        img[0] = MAGIC; img[1] = 32'h01020304; img[2] = 32'd14;
        img[3] = 0; img[4] = 5; img[5] = 1; img[6] = 10; img[7] = 32'hF;
        img[8] = 32'h10; img[9] = 3;
        for (int i = 7; i <= 9; i++) img[3+i] = 32'hC0DE0000 + 32'(i);
        img[13] = 32'h7FE; img[14] = 2;
        for (int i = 12; i <= 13; i++) img[3+i] = 32'hC0DE0000 + 32'(i);
        case (k)
            2:  img[0] = 32'h12345678;
            3:  img[2] = 32'd15;
            4:  img[1][27:24] = 4'd2;
            5:  img[1][31:28] = 4'd1;
            7:  img[7] = 32'd0;
            8:  img[4] = 32'd4;
            9:  img[6] = 32'd13;
            10: img[5] = 32'd2;
            11: img[13] = 32'h7FF;
            12: begin img[13] = 32'h7FF; img[1][31:28] = 4'd1; end
            13: img[9] = 32'd8;
            14: begin n = 40; img[2] = 32'd37;
                      for (int i = 17; i < 40; i++) img[i] = 32'h5A5A0000 + 32'(i); end
            default: ;
        endcase
        if (k == 1) for (int i = 0; i < n; i++) img[i] = sw(img[i]);
        return n;
    endfunction

    task automatic run_img(input int n);
        wn = 0; starts = 0; done_seen = 1'b0; err_seen = 4'hF;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_data = img[i]; in_last = (i == n - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        for (int t = 0; t < 3000 && !done_seen; t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R14 reset state
        chk(in_ready === 1'b1, "R14", "ready after reset", 64'(in_ready), 1);
        chk(done === 1'b0 && mem_we === 1'b0 && start === 1'b0, "R14", "idle outputs",
            64'({done, mem_we, start}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < VEC_N; k++) begin
            int n;
            n = build(k);
            cfg_new_gen    = (k == 12);
            engine_running = (k == 6);
            run_img(n);
            chk(done_seen && err_seen == VEC_ERR[k], req_of(k), "result code",
                64'(err_seen), 64'(VEC_ERR[k]));
            if (VEC_ERR[k] == 4'd0) begin
                logic [11:0] dbase;
                dbase = (k == 12) ? 12'h7FF : 12'h7FE;
                chk(wn == 5, "R12", "write count", 64'(wn), 5);
                chk(starts == 1, "R14", "start pulses", 64'(starts), 1);
                for (int i = 0; i < 5 && i < wn; i++) begin
                    logic [44:0] e;
                    if (i < 3) e = {1'b0, 12'h010 + 12'(i), 32'hC0DE0007 + 32'(i)};
                    else       e = {1'b1, dbase + 12'(i - 3), 32'hC0DE000C + 32'(i - 3)};
                    chk(wlog[i] == e, (k == 1) ? "R1" : "R12", "write entry", 64'(wlog[i]), 64'(e));
                end
            end else begin
                chk(wn == 0, "R13", "writes on failed load", 64'(wn), 0);
                chk(starts == 0, "R14", "start on failed load", 64'(starts), 0);
            end
        end
        cfg_new_gen = 1'b0; engine_running = 1'b0;

        // R6 empty table: end marker first, nothing written, load succeeds
        img[0] = MAGIC; img[1] = 32'h01000000; img[2] = 32'd2; img[3] = 32'hF; img[4] = 32'd0;
        run_img(5);
        chk(done_seen && err_seen == 4'd0, "R6", "empty table result", 64'(err_seen), 0);
        chk(wn == 0 && starts == 1, "R14", "empty table writes/start", 64'({wn, starts}), 64'(1));

        // R3 image shorter than the header
        img[0] = MAGIC; img[1] = 32'h01000000;
        run_img(2);
        chk(done_seen && err_seen == 4'd2, "R3", "short image", 64'(err_seen), 2);

        // R2 priority: bad magic and bad size together report magic
        void'(build(3));
        img[0] = 32'hDEADBEEF;
        run_img(17);
        chk(done_seen && err_seen == 4'd1, "R2", "magic priority", 64'(err_seen), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule